// File: doc/BRIEF.md
# Ramped Digital Volume Stage with Zero-Crossing Mute

This block scales a stream of signed 24-bit audio samples by a 24-bit unsigned gain. The gain has 3 integer bits and 21 fractional bits, so it covers 0 up to just under 8 times, and 0x200000 is unity. Samples enter and leave on valid/ready handshakes, and each result is saturated to the signed 24-bit range.

The gain actually applied is not the requested one. On each accepted sample it moves toward the requested target by a programmable step and stops exactly on the target. A mute request does not act at once. The mute state changes only on a sample where the signal crosses zero, so the audio is never cut in the middle of a waveform. The target, the step size and the mute request are plain input ports, and the stage sits directly between an audio source and a sink.

Top module: `vol_ramp`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: With the applied gain at unity (0x200000) and the stage unmuted, each output sample equals its input sample.
- R3: The output equals (sample × applied gain) arithmetically shifted right by 21 bits, which rounds toward minus infinity. The result is then clamped to the range 0x800000 (most negative) to 0x7FFFFF (most positive).
- R4: On every accepted sample, the applied gain moves toward `target_gain_i` by `ramp_step_i`. It lands exactly on the target and never passes it, in both directions. A sample is scaled by the gain held before that sample's own update.
- R5: Reset sets the applied gain to 0, so the first accepted sample after reset produces 0.
- R6: A mute request takes effect only on an accepted sample that is 0, or whose sign (negative or not) differs from the previous accepted sample. That sample and every later sample while muted produce 0. Before the first accepted sample after reset, the previous sample counts as non-negative.
- R7: Releasing a mute request likewise takes effect only at such a zero-crossing sample, and that sample is scaled normally.
- R8: An accepted sample appears on `out_sample_o` with `out_valid_o` high on the cycle after acceptance.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output holds its value and `in_ready_o` is low. No input is taken, and neither the gain ramp nor the zero-crossing tracking advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| target_gain_i | input | 24 | Requested gain, 3.21 unsigned fixed point |
| ramp_step_i | input | 24 | Maximum gain change per accepted sample |
| mute_req_i | input | 1 | 1 requests mute, 0 requests sound |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Stage can take an input sample |
| in_sample_i | input | 24 | Signed input sample |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Sink takes the output sample |
| out_sample_o | output | 24 | Signed scaled and saturated sample |

## Verification
A fault in the applied gain register shows up on the very next output as a wrong amplitude. Because the ramp accumulates, the error then persists, or grows, on every sample until the target is reached. A wrong mute state or wrong previous-sign bit shows up as a spurious zero, or a missing zero, on the sample where the switch was due or not due. That sample leaves the stage one cycle after it is accepted. A stall fault shows up either as a changed held output, or as a gain step taken without a transfer, which skews every later output.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int unsigned DEF_DATA_W = 24;
  localparam int unsigned DEF_GAIN_W = 24;
  localparam int unsigned DEF_FRAC_W = 21;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/vol_gain_ramp.sv
module vol_gain_ramp
  import vol_pkg::*;
#(
  parameter int unsigned GAIN_W = DEF_GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [GAIN_W-1:0] target_i,
  input  logic [GAIN_W-1:0] step_i,
  output logic [GAIN_W-1:0] gain_o
);
  ramp_dir_e         dir;
  logic [GAIN_W-1:0] gain_q, gap, gain_nxt;

  always_comb begin
    dir = RAMP_HOLD;
    gap = '0;
    if (target_i > gain_q) begin
      dir = RAMP_UP;
      gap = target_i - gain_q;
    end else if (target_i < gain_q) begin
      dir = RAMP_DOWN;
      gap = gain_q - target_i;
    end
  end

  // clamp to target when the step would cross it
  always_comb begin
    case (dir)
      RAMP_UP:   gain_nxt = (step_i >= gap) ? target_i : gain_q + step_i;
      RAMP_DOWN: gain_nxt = (step_i >= gap) ? target_i : gain_q - step_i;
      default:   gain_nxt = gain_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gain_q <= '0;
    else if (adv_i) gain_q <= gain_nxt;
  end

  assign gain_o = gain_q;

  a_r4_no_overshoot_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && gain_q <= target_i) |=> (gain_q <= $past(target_i) && gain_q >= $past(gain_q)));

  a_r4_no_overshoot_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && gain_q >= target_i) |=> (gain_q >= $past(target_i) && gain_q <= $past(gain_q)));

  a_r4_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (((gain_q >= $past(gain_q)) ? (gain_q - $past(gain_q))
                                         : ($past(gain_q) - gain_q)) <= $past(step_i)));

  a_r9_gain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(gain_q));
endmodule

// File: rtl/vol_zc_mute.sv
module vol_zc_mute
  import vol_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              mute_req_i,
  output logic              mute_eff_o
);
  logic muted_q, prev_neg_q, zc, muted_nxt;

  assign zc        = (sample_i == '0) || (sample_i[DATA_W-1] != prev_neg_q);
  assign muted_nxt = (zc && (mute_req_i != muted_q)) ? mute_req_i : muted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      muted_q    <= 1'b0;
      prev_neg_q <= 1'b0;
    end else if (adv_i) begin
      muted_q    <= muted_nxt;
      prev_neg_q <= sample_i[DATA_W-1];
    end
  end

  // the crossing sample already carries the new state
  assign mute_eff_o = muted_nxt;

  a_r6_switch_only_at_zc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && sample_i != '0 && sample_i[DATA_W-1] == prev_neg_q) |=> $stable(muted_q));

  a_r9_mute_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(muted_q) && $stable(prev_neg_q)));
endmodule

// File: rtl/vol_gain_mul.sv
module vol_gain_mul
  import vol_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned GAIN_W = DEF_GAIN_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned PW = DATA_W + GAIN_W + 1;

  logic signed [PW-1:0] prod, scaled;
  logic                 ovf;

  assign prod   = $signed(sample_i) * $signed({1'b0, gain_i});
  assign scaled = prod >>> FRAC_W;
  // out of range when bits above the result sign are not a sign extension
  assign ovf    = (scaled[PW-1:DATA_W-1] != {(PW-DATA_W+1){scaled[PW-1]}});

  always_comb begin
    if (!ovf)                result_o = scaled[DATA_W-1:0];
    else if (scaled[PW-1])   result_o = {1'b1, {(DATA_W-1){1'b0}}};
    else                     result_o = {1'b0, {(DATA_W-1){1'b1}}};
  end
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
  import vol_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned GAIN_W = DEF_GAIN_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAIN_W-1:0] target_gain_i,
  input  logic [GAIN_W-1:0] ramp_step_i,
  input  logic              mute_req_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_sample_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_sample_o
);
  logic              accept, mute_eff;
  logic [GAIN_W-1:0] gain;
  logic [DATA_W-1:0] scaled;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  vol_gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (accept),
    .target_i (target_gain_i),
    .step_i   (ramp_step_i),
    .gain_o   (gain)
  );

  vol_zc_mute #(.DATA_W(DATA_W)) u_zc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (accept),
    .sample_i   (in_sample_i),
    .mute_req_i (mute_req_i),
    .mute_eff_o (mute_eff)
  );

  vol_gain_mul #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_mul (
    .sample_i (in_sample_i),
    .gain_i   (gain),
    .result_o (scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (accept) begin
      out_valid_q <= 1'b1;
      out_data_q  <= mute_eff ? '0 : scaled;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_sample_o = out_data_q;

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  a_r9_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_sample_o)));
endmodule

// File: tb/vol_ramp_bench.sv
`timescale 1ns/1ps
module vol_ramp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] target_gain, ramp_step;
  logic        mute_req, in_valid, in_ready, out_valid, out_ready;
  logic [23:0] in_sample, out_sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vol_ramp u_vol_ramp (
    .clk_i(clk), .rst_ni(rst_n), .target_gain_i(target_gain), .ramp_step_i(ramp_step),
    .mute_req_i(mute_req), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sample_i(in_sample), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_sample_o(out_sample)
  );

  // reference model state
  longint      m_gain;
  bit          m_muted, m_prev_neg;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag;
  logic [23:0] tgt_v, step_v;
  bit          mreq_v;
  bit          lat_pend, hold_pend;
  logic [23:0] held;

  function automatic logic [23:0] ref_scale(longint s, longint g);
    longint p;
    p = (s * g) >>> 21;
    if (p > 64'sd8388607)  p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[23:0];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_accept(logic [23:0] d);
    longint s;
    bit zc;
    s  = longint'($signed(d));
    zc = (s == 0) || ((s < 0) != m_prev_neg);
    if (zc && (mreq_v != m_muted)) m_muted = mreq_v;
    exp_q.push_back(m_muted ? 24'h0 : ref_scale(s, m_gain));
    tag_q.push_back(cur_tag);
    if (m_gain < longint'(tgt_v))
      m_gain = (m_gain + longint'(step_v) > longint'(tgt_v)) ? longint'(tgt_v) : m_gain + longint'(step_v);
    else if (m_gain > longint'(tgt_v))
      m_gain = (m_gain - longint'(step_v) < longint'(tgt_v)) ? longint'(tgt_v) : m_gain - longint'(step_v);
    m_prev_neg = (s < 0);
  endtask

  // one clock: check previous edge, drive, then evaluate transfers before next edge
  task automatic cyc(bit v, logic [23:0] d, bit ordy);
    logic [23:0] e;
    string t;
    @(negedge clk);
    if (lat_pend)  check(out_valid === 1'b1, "R8", "out_valid after accept", out_valid, 1);
    if (hold_pend) begin
      check(out_valid === 1'b1, "R9", "valid held", out_valid, 1);
      check(out_sample === held, "R9", "data held", out_sample, held);
    end
    target_gain = tgt_v;
    ramp_step   = step_v;
    mute_req    = mreq_v;
    in_valid    = v;
    in_sample   = d;
    out_ready   = ordy;
    #1;
    check(in_ready === (!out_valid || out_ready), "R9", "in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R8", "unexpected output", out_sample, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_sample === e, t, "sample", out_sample, e);
      end
    end
    lat_pend  = in_valid && in_ready;
    hold_pend = out_valid && !out_ready;
    held      = out_sample;
    if (lat_pend) model_accept(d);
  endtask

  task automatic send(logic [23:0] d);
    cyc(1'b1, d, 1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) cyc(1'b0, 24'h0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd918273));
    m_gain = 0; m_muted = 0; m_prev_neg = 0;
    lat_pend = 0; hold_pend = 0; held = '0;
    tgt_v = 24'h200000; step_v = 24'h200000; mreq_v = 1'b0;
    target_gain = tgt_v; ramp_step = step_v; mute_req = 1'b0;
    in_valid = 1'b0; in_sample = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // first sample uses reset gain 0
    cur_tag = "R5";
    send(24'h123456);
    cur_tag = "R2";
    send(24'h000500); send(24'h7FFFFF); send(24'h800000); send(24'hFFFFFF);
    drain();

    // mute engages only at a crossing
    cur_tag = "R6";
    send(24'h000600);
    mreq_v = 1'b1;
    send(24'h000700);
    send(24'h000710);
    send(24'hFFFFFB);
    send(24'h000300);
    // unmute waits for a crossing
    cur_tag = "R7";
    mreq_v = 1'b0;
    send(24'h000400);
    send(24'h000000);
    send(24'h000250);
    drain();

    // down ramp with a step that does not divide the distance
    cur_tag = "R4";
    tgt_v = 24'h100000; step_v = 24'h030000;
    for (int i = 0; i < 8; i++) send(24'h004000);
    tgt_v = 24'h200000; step_v = 24'h050000;
    for (int i = 0; i < 5; i++) send(24'hFFC000);
    drain();

    // rounding and clamping
    cur_tag = "R3";
    tgt_v = 24'h100000; step_v = 24'hFFFFFF;
    send(24'h000001); send(24'hFFFFFD); send(24'hFFFFFD);
    tgt_v = 24'hFFFFFF;
    send(24'h000003); send(24'h7FFFFF); send(24'h800000); send(24'h100000); send(24'hF00000);
    drain();

    // stalls under random backpressure
    cur_tag = "R9";
    tgt_v = 24'h080000; step_v = 24'h001000;
    for (int i = 0; i < 300; i++)
      cyc(($urandom % 4) != 0, 24'($urandom), ($urandom % 3) == 0);
    drain();

    // mixed random traffic
    cur_tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] d;
      int k;
      if (($urandom % 60) == 0) begin
        tgt_v  = 24'($urandom);
        step_v = 24'($urandom % 32'h80000);
      end
      if (($urandom % 40) == 0) mreq_v = !mreq_v;
      k = $urandom % 5;
      if (k == 0)      d = 24'($signed(($urandom % 9)) - 4);
      else if (k == 1) d = ($urandom % 2) ? 24'h7FFFFF : 24'h800000;
      else             d = 24'($urandom);
      cyc(($urandom % 4) != 0, d, ($urandom % 10) < 7);
    end
    drain();
    check(exp_q.size() == 0, "R8", "outputs outstanding", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule